// File: doc/BRIEF.md
# Reader Forward-Link Gap Modulator

This block keys the reader's low-frequency field on and off to send a command downlink to a read/write transponder. Bits are coded as gaps in the field. Every duration is a whole number of carrier cycles. At 125 kHz one carrier cycle lasts 8 µs, and a prescaler derives each cycle from the system clock.

A controller supplies a bit vector, a bit count, a read/write flag and a one-cycle start strobe. The block captures these operands when it starts, so they may change freely while it runs. The first bit slot always carries a long start gap. Each later 1 bit holds the field on. Each later 0 bit opens a short gap. After the last bit the block pulses `done_o` and holds the field on for a settle time that depends on the command type. It then pulses `capture_ready_o` so the acquisition logic can start sampling the tag's reply.

Command assembly and sample acquisition belong to neighbouring blocks.

Top module: `fwd_gap_mod`

## Requirements
- R1: Out of reset and whenever idle, `field_on_o` is 1 and `busy_o`, `done_o` and `capture_ready_o` are 0.
- R2: A start accepted at a clock edge drives the field off from the next cycle for 55 carrier cycles, then on for 18. This start gap stands for bit 0, whatever that bit's value.
- R3: Each later bit equal to 1 keeps the field on for 32 carrier cycles, with no gap.
- R4: Each later bit equal to 0 drives the field off for 23 carrier cycles, then on for 18.
- R5: Bits are sent LSB first: bit 0 is the start gap, followed by bits 1 through N-1, where N is `bit_cnt_i`. A count of 0 or 1 sends the start gap only.
- R6: `done_o` is a one-cycle pulse in the first cycle after the last bit's field-on time ends. The field stays on from then until the block is idle.
- R7: `capture_ready_o` pulses for one cycle after a settle time measured from `done_o`. The settle time is 50 carrier cycles (400 µs) for a read (`is_write_i`=0) and 813 carrier cycles (6500 µs, rounded up) for a write (`is_write_i`=1). `busy_o` is 1 from the cycle after the start until that pulse.
- R8: A start strobe seen while `busy_o` is 1 has no effect, including in the last settle cycle. Bits, count and the write flag are captured only when a start is accepted.
- R9: A start strobe in the cycle where `capture_ready_o` is 1 is accepted and begins a new frame.
- R10: Every carrier cycle lasts exactly `CLK_PER_CARRIER` system clocks. The carrier prescaler restarts at each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, acted on only when idle |
| is_write_i | input | 1 | 1 selects the write settle time, 0 the read settle time |
| bit_cnt_i | input | CNT_W | Number of bits, including the start-gap bit |
| bits_i | input | MAX_BITS | Command bits, bit 0 sent first |
| field_on_o | output | 1 | Reader field enable, 1 = carrier on |
| busy_o | output | 1 | Frame or settle in progress |
| done_o | output | 1 | One-cycle pulse when the last bit has been sent |
| capture_ready_o | output | 1 | One-cycle pulse when reply capture may begin |

## Verification
Two events can meet in one cycle: the end of one frame, marked by `capture_ready_o`, and the start strobe of the next. The bench chains two frames by raising start exactly in the capture-ready cycle. It then requires the second frame's start gap to begin on the following cycle, with no idle cycle in between. In every frame it also raises start in the last settle cycle, one cycle earlier. It judges that strobe by checking that `busy_o` still falls on time and that the field then stays idle-high.

// File: rtl/fwd_gap_mod_pkg.sv
package fwd_gap_mod_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_CARRIER,
        ST_SETTLE
    } gm_state_e;

    // carrier-cycle durations of the symbol pieces
    localparam int unsigned SOF_OFF_CYC   = 55;
    localparam int unsigned SOF_ON_CYC    = 18;
    localparam int unsigned ONE_ON_CYC    = 32;
    localparam int unsigned ZERO_OFF_CYC  = 23;
    localparam int unsigned ZERO_ON_CYC   = 18;
    localparam int unsigned RD_SETTLE_CYC = 50;
    localparam int unsigned WR_SETTLE_CYC = 813;

endpackage

// File: rtl/fwd_gap_tick.sv
module fwd_gap_tick #(
    parameter int unsigned CLK_PER_CARRIER = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    generate
        if (CLK_PER_CARRIER <= 1) begin : g_passthru
            assign tick_o = 1'b1;
        end else begin : g_prescale
            localparam int unsigned PW = $clog2(CLK_PER_CARRIER);
            localparam logic [PW-1:0] LAST = PW'(CLK_PER_CARRIER - 1);

            logic [PW-1:0] pre_d, pre_q;

            always_comb begin
                if (clr_i || pre_q == LAST) pre_d = '0;
                else                        pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick_o = (pre_q == LAST);

            // R10
            tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/fwd_gap_bitq.sv
module fwd_gap_bitq #(
    parameter int unsigned MAX_BITS = 64,
    parameter int unsigned CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                adv_i,
    input  logic [MAX_BITS-1:0] bits_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic                next_bit_o,
    output logic                more_o
);

    typedef struct packed {
        logic [MAX_BITS-1:0] sr;
        logic [CNT_W-1:0]    rem;
    } bq_t;

    bq_t bq_d, bq_q;

    always_comb begin
        bq_d = bq_q;
        if (load_i) begin
            bq_d.sr  = bits_i >> 1;   // bit 0 is the start gap
            bq_d.rem = cnt_i;
        end else if (adv_i) begin
            bq_d.sr  = bq_q.sr >> 1;
            bq_d.rem = bq_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bq_q <= '0;
        else        bq_q <= bq_d;
    end

    assign next_bit_o = bq_q.sr[0];
    assign more_o     = (bq_q.rem > CNT_W'(1));

    // R8
    sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(bq_q));

    // R5
    adv_needs_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |-> more_o);

endmodule

// File: rtl/fwd_gap_mod.sv
module fwd_gap_mod
    import fwd_gap_mod_pkg::*;
#(
    parameter int unsigned CLK_PER_CARRIER = 400,
    parameter int unsigned MAX_BITS        = 64,
    parameter int unsigned SOF_OFF         = SOF_OFF_CYC,
    parameter int unsigned SOF_ON          = SOF_ON_CYC,
    parameter int unsigned ONE_ON          = ONE_ON_CYC,
    parameter int unsigned ZERO_OFF        = ZERO_OFF_CYC,
    parameter int unsigned ZERO_ON         = ZERO_ON_CYC,
    parameter int unsigned RD_SETTLE       = RD_SETTLE_CYC,
    parameter int unsigned WR_SETTLE       = WR_SETTLE_CYC,
    parameter int unsigned CNT_W           = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                is_write_i,
    input  logic [CNT_W-1:0]    bit_cnt_i,
    input  logic [MAX_BITS-1:0] bits_i,
    output logic                field_on_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                capture_ready_o
);

    localparam int unsigned M1      = (SOF_OFF > SOF_ON) ? SOF_OFF : SOF_ON;
    localparam int unsigned M2      = (ONE_ON > ZERO_OFF) ? ONE_ON : ZERO_OFF;
    localparam int unsigned M3      = (ZERO_ON > RD_SETTLE) ? ZERO_ON : RD_SETTLE;
    localparam int unsigned M12     = (M1 > M2) ? M1 : M2;
    localparam int unsigned M123    = (M12 > M3) ? M12 : M3;
    localparam int unsigned MAX_LEN = (M123 > WR_SETTLE) ? M123 : WR_SETTLE;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    localparam logic [LEN_W-1:0] L_SOF_OFF   = LEN_W'(SOF_OFF);
    localparam logic [LEN_W-1:0] L_SOF_ON    = LEN_W'(SOF_ON);
    localparam logic [LEN_W-1:0] L_ONE_ON    = LEN_W'(ONE_ON);
    localparam logic [LEN_W-1:0] L_ZERO_OFF  = LEN_W'(ZERO_OFF);
    localparam logic [LEN_W-1:0] L_ZERO_ON   = LEN_W'(ZERO_ON);
    localparam logic [LEN_W-1:0] L_RD_SETTLE = LEN_W'(RD_SETTLE);
    localparam logic [LEN_W-1:0] L_WR_SETTLE = LEN_W'(WR_SETTLE);

    typedef struct packed {
        gm_state_e        st;
        logic [LEN_W-1:0] ph;
        logic             field;
        logic             done;
        logic             cap;
        logic             wr;
        logic             first;
        logic             one;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic tick;
    logic load, adv, clr;
    logic next_bit, more;
    logic [LEN_W-1:0] off_len, on_len, settle_len;

    fwd_gap_tick #(
        .CLK_PER_CARRIER (CLK_PER_CARRIER)
    ) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .tick_o (tick)
    );

    fwd_gap_bitq #(
        .MAX_BITS (MAX_BITS),
        .CNT_W    (CNT_W)
    ) i_bitq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .adv_i      (adv),
        .bits_i     (bits_i),
        .cnt_i      (bit_cnt_i),
        .next_bit_o (next_bit),
        .more_o     (more)
    );

    always_comb begin
        off_len    = fsm_q.first ? L_SOF_OFF : L_ZERO_OFF;
        on_len     = fsm_q.first ? L_SOF_ON
                                 : (fsm_q.one ? L_ONE_ON : L_ZERO_ON);
        settle_len = fsm_q.wr ? L_WR_SETTLE : L_RD_SETTLE;
    end

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        fsm_d.cap  = 1'b0;
        load       = 1'b0;
        adv        = 1'b0;
        clr        = 1'b0;

        unique case (fsm_q.st)
            ST_IDLE: begin
                fsm_d.field = 1'b1;
                if (start_i) begin
                    load        = 1'b1;
                    clr         = 1'b1;
                    fsm_d.st    = ST_GAP;
                    fsm_d.ph    = '0;
                    fsm_d.field = 1'b0;
                    fsm_d.wr    = is_write_i;
                    fsm_d.first = 1'b1;
                    fsm_d.one   = 1'b0;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (fsm_q.ph == off_len - 1'b1) begin
                        fsm_d.st    = ST_CARRIER;
                        fsm_d.ph    = '0;
                        fsm_d.field = 1'b1;
                    end else begin
                        fsm_d.ph = fsm_q.ph + 1'b1;
                    end
                end
            end
            ST_CARRIER: begin
                if (tick) begin
                    if (fsm_q.ph == on_len - 1'b1) begin
                        fsm_d.ph = '0;
                        if (more) begin
                            adv         = 1'b1;
                            fsm_d.first = 1'b0;
                            fsm_d.one   = next_bit;
                            fsm_d.st    = next_bit ? ST_CARRIER : ST_GAP;
                            fsm_d.field = next_bit;
                        end else begin
                            fsm_d.st   = ST_SETTLE;
                            fsm_d.done = 1'b1;
                        end
                    end else begin
                        fsm_d.ph = fsm_q.ph + 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tick) begin
                    if (fsm_q.ph == settle_len - 1'b1) begin
                        fsm_d.st  = ST_IDLE;
                        fsm_d.ph  = '0;
                        fsm_d.cap = 1'b1;
                    end else begin
                        fsm_d.ph = fsm_q.ph + 1'b1;
                    end
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.st    <= ST_IDLE;
            fsm_q.field <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign field_on_o      = fsm_q.field;
    assign busy_o          = (fsm_q.st != ST_IDLE);
    assign done_o          = fsm_q.done;
    assign capture_ready_o = fsm_q.cap;

    // R1
    idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> field_on_o);

    // R2
    gap_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(field_on_o) |-> busy_o);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && field_on_o && busy_o));

    // R7
    cap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> capture_ready_o);

    // R7
    cap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_ready_o |-> (!busy_o && !done_o));

endmodule

// File: tb/test_fwd_gap_mod.sv
module test_fwd_gap_mod;

    localparam int P      = 2;
    localparam int NB     = 8;
    localparam int CW     = $clog2(NB + 1);
    localparam int RD_S   = 50;
    localparam int WR_S   = 813;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          is_write_i = 1'b0;
    logic [CW-1:0] bit_cnt_i = '0;
    logic [NB-1:0] bits_i = '0;
    logic          field_on_o, busy_o, done_o, capture_ready_o;

    int tests = 0;
    int fails = 0;
    logic exp_f [0:4095];

    always #10 clk = ~clk;

    fwd_gap_mod #(
        .CLK_PER_CARRIER (P),
        .MAX_BITS        (NB)
    ) i_fwd_gap_mod (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .is_write_i      (is_write_i),
        .bit_cnt_i       (bit_cnt_i),
        .bits_i          (bits_i),
        .field_on_o      (field_on_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .capture_ready_o (capture_ready_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge
    task automatic run_frame(input logic [NB-1:0] bits, input int cnt, input bit wr,
                             input int poke, input int tail, input string req);
        int t, s, fin;
        int ef, ed, ec, eb;
        int fi;
        t = 0;
        for (int k = 0; k < 55 * P; k++) begin exp_f[t] = 1'b0; t++; end
        for (int k = 0; k < 18 * P; k++) begin exp_f[t] = 1'b1; t++; end
        for (int b = 1; b < cnt; b++) begin
            if (bits[b]) begin
                for (int k = 0; k < 32 * P; k++) begin exp_f[t] = 1'b1; t++; end
            end else begin
                for (int k = 0; k < 23 * P; k++) begin exp_f[t] = 1'b0; t++; end
                for (int k = 0; k < 18 * P; k++) begin exp_f[t] = 1'b1; t++; end
            end
        end
        s   = wr ? WR_S : RD_S;
        fin = t + s * P;
        ef = 0; ed = 0; ec = 0; eb = 0; fi = -1;

        bits_i     = bits;
        bit_cnt_i  = CW'(cnt);
        is_write_i = wr;
        start_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R8: operands change after capture
        bits_i     = ~bits;
        bit_cnt_i  = ~CW'(cnt);
        is_write_i = !wr;
        for (int i = 0; i <= fin + tail; i++) begin
            if (i > 0) @(negedge clk);
            start_i = (i == poke) || (i == fin - 1);
            if (field_on_o !== ((i < t) ? exp_f[i] : 1'b1)) begin
                ef++;
                if (fi < 0) fi = i;
            end
            if (done_o !== (i == t)) ed++;
            if (capture_ready_o !== (i == fin)) ec++;
            if (busy_o !== (i < fin)) eb++;
        end
        if (tail > 0) start_i = 1'b0;
        check(ef == 0, {req, " field waveform, first bad sample"}, fi, -1);
        // R6
        check(ed == 0, "R6 done pulse timing mismatches", ed, 0);
        // R7
        check(ec == 0, "R7 capture_ready timing mismatches", ec, 0);
        check(eb == 0, "R7 busy window mismatches", eb, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(field_on_o === 1'b1, "R1 field in reset", field_on_o, 1);
        check(busy_o === 1'b0, "R1 busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(field_on_o === 1'b1, "R1 idle field", field_on_o, 1);
        check(busy_o === 1'b0, "R1 idle busy", busy_o, 0);
        check(done_o === 1'b0 && capture_ready_o === 1'b0, "R1 idle pulses",
              {done_o, capture_ready_o}, 0);

        // R2: start gap independent of bit 0, counts 0 and 1
        run_frame(8'h01, 1, 1'b0, -1, 4, "R2");
        run_frame(8'h00, 1, 1'b0, -1, 4, "R2");
        run_frame(8'hFF, 0, 1'b0, -1, 4, "R5");
        // R3 all ones
        run_frame(8'hFF, 8, 1'b0, -1, 4, "R3");
        // R4 all zeros
        run_frame(8'h00, 8, 1'b0, -1, 4, "R4");
        // R7 write settle
        run_frame(8'h5A, 8, 1'b1, -1, 4, "R7");
        run_frame(8'h03, 3, 1'b1, -1, 4, "R7");
        // R8 start strobe during gap and carrier
        run_frame(8'h96, 8, 1'b0, 40, 4, "R8");
        run_frame(8'h96, 8, 1'b0, 200, 4, "R8");
        // R9 back-to-back: next start in the capture_ready cycle
        run_frame(8'h0D, 4, 1'b0, -1, 0, "R9");
        run_frame(8'hB2, 6, 1'b0, -1, 4, "R9");
        // R5 count sweep
        for (int c = 0; c <= NB; c++)
            run_frame(8'hA5, c, c[0], -1, 2, "R5");
        // R5 / R10 pattern sweep, LSB first
        for (int p = 0; p < 64; p++)
            run_frame(8'(p << 1) | 8'(p[0]), 7, 1'b0, -1, 1, "R10");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule